// File: doc/BRIEF.md
# Display Power Request Controller

This block accepts host commands that switch three display supplies: the LCD panel voltage, the bottom-screen backlight and the top-screen backlight. Each supply has its own pair of request bits in a write-only command word. One bit of the pair asks for the supply to turn on and the other asks for it to turn off. A per-supply sequencer takes each request, waits a settle time set by a parameter, and then drives the rail enable output. The same rail states appear in a status byte that the host can read.

The panel-voltage request is acknowledged at once, and its request bits self-clear one cycle after the write. Backlight request bits stay readable until the rail has reached the requested state, so the host can poll them to see that a backlight change is still in progress. On builds with a single backlight, a configuration input masks the top-backlight request bits. A build parameter can also remove the top channel completely.

Top module: `disp_pwr_req_ctrl`

## Requirements
- R1: While reset is asserted and after its release, with no write made, req_rd, status and all three rail enables are zero.
- R2: In each pair (bit 0 panel off / bit 1 panel on, bit 2 bottom off / bit 3 bottom on, bit 4 top off / bit 5 top on), writing both bits at once is treated as an off request. Only the off bit of that pair then reads back as set.
- R3: The panel request bits req_rd[1:0] read back as the written request for exactly one cycle after the write edge and then return to zero. No other write is needed to clear them.
- R4: A backlight request bit in req_rd[5:2] stays set from the write edge until the clock edge on which its rail takes the requested value. It clears on that same edge.
- R5: panel_en takes the requested value PANEL_SETTLE clock edges after the write edge.
- R6: bot_bl_en and top_bl_en take the requested value BL_SETTLE clock edges after the write edge. A rail never rises unless its on-request bit was set on the cycle before.
- R7: status bit 7 equals panel_en, bit 6 equals top_bl_en, bit 5 equals bot_bl_en, and bits 4:0 are zero.
- R8: While single_bl is high, write bits 5:4 have no effect: req_rd[5:4] and top_bl_en do not change because of them.
- R9: A write whose pair for a supply is 2'b00 leaves that supply's pending request and countdown untouched. A non-zero pair written during a countdown replaces the target and restarts the settle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the request word |
| wr_data | input | 6 | Request word, one off/on bit pair per supply |
| single_bl | input | 1 | High on single-backlight builds; masks the top-backlight request bits |
| req_rd | output | 6 | Read-back of the pending request bits |
| status | output | 8 | Rail status flags (bit 7 panel, bit 6 top, bit 5 bottom) |
| panel_en | output | 1 | LCD panel voltage enable |
| bot_bl_en | output | 1 | Bottom backlight enable |
| top_bl_en | output | 1 | Top backlight enable |

## Verification
The bench builds the block with PANEL_SETTLE = 3, BL_SETTLE = 5 and HAS_TOP_BL = 1. With these short settle windows, random writes often arrive in the middle of a countdown, so restarts, overlapping panel and backlight changes and off-wins collisions all occur many times per run. Keeping the top channel in the build lets the single_bl input be toggled during the run, which tests the runtime mask on both idle and busy top-backlight state.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   localparam int NUM_RAILS = 3;
   localparam int REQ_W     = 2 * NUM_RAILS;
   localparam int STAT_W    = 8;

   localparam int IDX_PANEL = 0;
   localparam int IDX_BOT   = 1;
   localparam int IDX_TOP   = 2;

   typedef struct packed {
      logic valid;
      logic turn_on;
   } rail_cmd_t;

   // off bit is the low bit of a pair and takes priority
   function automatic rail_cmd_t pair_to_cmd(input logic [1:0] pair);
      rail_cmd_t c;
      c.valid   = |pair;
      c.turn_on = pair[1] & ~pair[0];
      return c;
   endfunction

endpackage

// File: rtl/dpr_req_decode.sv
module dpr_req_decode
   import dpr_pkg::*;
#(
   parameter int RAILS = NUM_RAILS
)(
   input  logic                           wr_en,
   input  logic [2*RAILS-1:0]             wr_data,
   input  logic [RAILS-1:0]               rail_mask,
   output rail_cmd_t [RAILS-1:0]          cmd_o
);

   if (RAILS < 1) begin : g_bad_rails
      $error("dpr_req_decode: RAILS must be at least 1");
   end

   for (genvar r = 0; r < RAILS; r++) begin : g_rail
      rail_cmd_t raw;
      always_comb begin
         raw            = pair_to_cmd(wr_data[2*r +: 2]);
         cmd_o[r].valid   = wr_en & rail_mask[r] & raw.valid;
         cmd_o[r].turn_on = raw.turn_on;
      end
   end

endmodule

// File: rtl/dpr_rail_chan.sv
module dpr_rail_chan
   import dpr_pkg::*;
#(
   parameter int SETTLE   = 16,
   parameter bit SELF_ACK = 1'b0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  rail_cmd_t  cmd_i,
   output logic [1:0] req_o,
   output logic       en_o
);

   localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

   if (SETTLE < 1) begin : g_bad_settle
      $error("dpr_rail_chan: SETTLE must be at least 1");
   end

   logic             busy_q;
   logic             tgt_q;
   logic [CNT_W-1:0] cnt_q;
   logic             settle_done;

   assign settle_done = busy_q && (cnt_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tgt_q  <= 1'b0;
         cnt_q  <= '0;
         en_o   <= 1'b0;
      end else if (cmd_i.valid) begin
         busy_q <= 1'b1;
         tgt_q  <= cmd_i.turn_on;
         cnt_q  <= '0;
      end else if (settle_done) begin
         busy_q <= 1'b0;
         en_o   <= tgt_q;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   if (SELF_ACK) begin : g_ack_now
      // request bits live for the single cycle that acknowledges them
      always_ff @(posedge clk) begin
         if (!rst_n)           req_o <= 2'b00;
         else if (cmd_i.valid) req_o <= cmd_i.turn_on ? 2'b10 : 2'b01;
         else                  req_o <= 2'b00;
      end
   end else begin : g_ack_done
      // request bits live until the rail has taken the new value
      always_ff @(posedge clk) begin
         if (!rst_n)           req_o <= 2'b00;
         else if (cmd_i.valid) req_o <= cmd_i.turn_on ? 2'b10 : 2'b01;
         else if (settle_done) req_o <= 2'b00;
      end
   end

endmodule

// File: rtl/disp_pwr_req_ctrl.sv
module disp_pwr_req_ctrl
   import dpr_pkg::*;
#(
   parameter int PANEL_SETTLE = 16,
   parameter int BL_SETTLE    = 40,
   parameter bit HAS_TOP_BL   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REQ_W-1:0]  wr_data,
   input  logic              single_bl,
   output logic [REQ_W-1:0]  req_rd,
   output logic [STAT_W-1:0] status,
   output logic              panel_en,
   output logic              bot_bl_en,
   output logic              top_bl_en
);

   localparam int STAT_PANEL = STAT_W - 1;
   localparam int STAT_TOP   = STAT_W - 2;
   localparam int STAT_BOT   = STAT_W - 3;

   if (PANEL_SETTLE < 1 || BL_SETTLE < 1) begin : g_bad_params
      $error("disp_pwr_req_ctrl: settle counts must be at least 1");
   end

   rail_cmd_t [NUM_RAILS-1:0] cmd_w;
   logic      [NUM_RAILS-1:0] mask_w;
   logic      [1:0]           req_panel, req_bot, req_top;

   assign mask_w[IDX_PANEL] = 1'b1;
   assign mask_w[IDX_BOT]   = 1'b1;
   assign mask_w[IDX_TOP]   = HAS_TOP_BL & ~single_bl;

   dpr_req_decode #(.RAILS(NUM_RAILS)) u_dec (
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rail_mask (mask_w),
      .cmd_o     (cmd_w)
   );

   dpr_rail_chan #(.SETTLE(PANEL_SETTLE), .SELF_ACK(1'b1)) u_panel (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd_i (cmd_w[IDX_PANEL]),
      .req_o (req_panel),
      .en_o  (panel_en)
   );

   dpr_rail_chan #(.SETTLE(BL_SETTLE), .SELF_ACK(1'b0)) u_bot (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd_i (cmd_w[IDX_BOT]),
      .req_o (req_bot),
      .en_o  (bot_bl_en)
   );

   if (HAS_TOP_BL) begin : g_top
      dpr_rail_chan #(.SETTLE(BL_SETTLE), .SELF_ACK(1'b0)) u_top (
         .clk   (clk),
         .rst_n (rst_n),
         .cmd_i (cmd_w[IDX_TOP]),
         .req_o (req_top),
         .en_o  (top_bl_en)
      );
   end else begin : g_no_top
      assign req_top   = 2'b00;
      assign top_bl_en = 1'b0;
   end

   assign req_rd = {req_top, req_bot, req_panel};

   always_comb begin
      status             = '0;
      status[STAT_PANEL] = panel_en;
      status[STAT_TOP]   = top_bl_en;
      status[STAT_BOT]   = bot_bl_en;
   end

endmodule

// File: rtl/dpr_chk.sv
module dpr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [5:0] wr_data,
   input logic       single_bl,
   input logic [5:0] req_rd,
   input logic       bot_bl_en,
   input logic       top_bl_en
);

   AST_PAIR_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_rd[1:0]) <= 1 && $countones(req_rd[3:2]) <= 1 && $countones(req_rd[5:4]) <= 1); // R2

   AST_PANEL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rd[1:0] != 2'b00 && !(wr_en && wr_data[1:0] != 2'b00)) |=> req_rd[1:0] == 2'b00); // R3

   AST_BOT_CLEARS_WITH_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(bot_bl_en) && !$past(wr_en && wr_data[3:2] != 2'b00)) |-> req_rd[3:2] == 2'b00); // R4

   AST_BOT_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bot_bl_en) |-> $past(req_rd[3])); // R6

   AST_TOP_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(top_bl_en) |-> $past(req_rd[5])); // R6

   AST_TOP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (single_bl && $past(single_bl) && $past(req_rd[5:4]) == 2'b00) |-> (req_rd[5:4] == 2'b00 && $stable(top_bl_en))); // R8

endmodule

bind disp_pwr_req_ctrl dpr_chk u_dpr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .single_bl (single_bl),
   .req_rd    (req_rd),
   .bot_bl_en (bot_bl_en),
   .top_bl_en (top_bl_en)
);

// File: tb/disp_pwr_req_ctrl_tb_top.sv
module disp_pwr_req_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int P_SET      = 3;
   localparam int B_SET      = 5;
   localparam int WD_CYCLES  = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_data = '0;
   logic       single_bl = 1'b0;
   logic [5:0] req_rd;
   logic [7:0] status;
   logic       panel_en, bot_bl_en, top_bl_en;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;

   int       m_en  [3];
   int       m_tgt [3];
   int       m_rem [3];
   logic [1:0] m_req [3];

   always #(CLK_PERIOD/2) clk = ~clk;

   disp_pwr_req_ctrl #(
      .PANEL_SETTLE (P_SET),
      .BL_SETTLE    (B_SET),
      .HAS_TOP_BL   (1'b1)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .single_bl (single_bl),
      .req_rd    (req_rd),
      .status    (status),
      .panel_en  (panel_en),
      .bot_bl_en (bot_bl_en),
      .top_bl_en (top_bl_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R3 panel request bits", 32'(req_rd[1:0]), 32'(m_req[0]));
      chk("R4 backlight request bits", 32'(req_rd[5:2]), 32'({m_req[2], m_req[1]}));
      chk("R5 panel rail", 32'(panel_en), 32'(m_en[0]));
      chk("R6 bottom rail", 32'(bot_bl_en), 32'(m_en[1]));
      chk("R6 top rail", 32'(top_bl_en), 32'(m_en[2]));
      chk("R7 status byte", 32'(status),
          32'({m_en[0][0], m_en[2][0], m_en[1][0], 5'b00000}));
   endtask

   task automatic model_adv(input logic wr, input logic [5:0] d, input logic sb);
      for (int r = 0; r < 3; r++) begin
         logic [1:0] pair;
         bit         app;
         pair = d[2*r +: 2];
         app  = wr && (pair != 2'b00) && !(r == 2 && sb);
         if (app) begin
            m_tgt[r] = pair[0] ? 0 : 1;
            m_req[r] = pair[0] ? 2'b01 : 2'b10;
            m_rem[r] = (r == 0) ? P_SET : B_SET;
         end else begin
            if (r == 0) m_req[r] = 2'b00;
            if (m_rem[r] > 0) begin
               m_rem[r]--;
               if (m_rem[r] == 0) begin
                  m_en[r] = m_tgt[r];
                  if (r != 0) m_req[r] = 2'b00;
               end
            end
         end
      end
   endtask

   // called at a falling edge: check, advance model, drive, wait next falling edge
   task automatic cyc(input logic wr, input logic [5:0] d, input logic sb);
      compare();
      model_adv(wr, d, sb);
      wr_en     = wr;
      wr_data   = d;
      single_bl = sb;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input logic sb);
      for (int i = 0; i < n; i++) cyc(1'b0, 6'b000000, sb);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      logic sb;
      void'($urandom(32'd4242));
      for (int r = 0; r < 3; r++) begin
         m_en[r] = 0; m_tgt[r] = 0; m_rem[r] = 0; m_req[r] = 2'b00;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset req_rd", 32'(req_rd), 32'd0);
      chk("R1 reset status", 32'(status), 32'd0);
      chk("R1 reset rails", 32'({panel_en, bot_bl_en, top_bl_en}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 32'({req_rd, status, panel_en, bot_bl_en, top_bl_en}), 32'd0);

      // all on, then all off with both bits of every pair set
      cyc(1'b1, 6'b101010, 1'b0);
      chk("R3 panel on request visible", 32'(req_rd[1:0]), 32'd2);
      idle(8, 1'b0);
      chk("R7 all rails on", 32'(status), 32'hE0);
      cyc(1'b1, 6'b111111, 1'b0);
      chk("R2 off wins in every pair", 32'(req_rd), 32'h15);
      idle(8, 1'b0);
      chk("R2 rails off after collision", 32'({panel_en, bot_bl_en, top_bl_en}), 32'd0);

      // R9: zero pair leaves bottom countdown alone; restart on new request
      cyc(1'b1, 6'b001000, 1'b0);
      idle(2, 1'b0);
      cyc(1'b1, 6'b000010, 1'b0);
      chk("R9 bottom still pending", 32'(req_rd[3:2]), 32'd2);
      idle(1, 1'b0);
      cyc(1'b1, 6'b000100, 1'b0);
      idle(3, 1'b0);
      chk("R9 restart holds bottom low", 32'(bot_bl_en), 32'd0);
      idle(6, 1'b0);

      // R8: masked top requests
      cyc(1'b0, 6'b000000, 1'b1);
      cyc(1'b1, 6'b100000, 1'b1);
      chk("R8 top request ignored", 32'(req_rd[5:4]), 32'd0);
      idle(8, 1'b1);
      chk("R8 top rail unchanged", 32'(top_bl_en), 32'd0);

      // random phase
      sb = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         logic       w;
         logic [5:0] d;
         if (i % 500 == 499) sb = ~sb;
         w = ($urandom % 4) == 0;
         d = 6'($urandom);
         cyc(w, d, sb);
      end
      idle(10, 1'b0);
      compare();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule